// File: doc/BRIEF.md
# Three-Way Set-Associative Tag Lookup with Exact LRU Replacement

This block is the tag side of a three-way set-associative cache working on 32-bit byte addresses. For each request it splits the address into line offset, set index and tag. It compares the tag with all three ways of the addressed set at once and reports whether the request hit and in which way. On a miss it picks the way that receives the new line, installs the tag there and reports whether a valid line was displaced. Line data, write handling and the path to the next memory level belong to the surrounding cache. They use the reported way to steer their own arrays.

Each set keeps the complete use order of its three ways, from most recent to least recent, packed into a 3-bit code. Every accepted request moves the accessed way to the front of that order, so the replacement choice is always the way that has gone unused the longest. One request can be accepted per clock. The stored state is updated on the same edge that accepts the request, and the response appears in registers one cycle later.

Top module: `lru3_tag_unit`

## Requirements
- R1: The address field boundaries are fixed. Bits [3:0] select a byte in the 16-byte line and take no part in the lookup. Bits [11:4] pick one of 256 sets. Bits [31:12] form the 20-bit tag.
- R2: A request is accepted on a clock edge where `req_valid` is 1. On the next cycle `rsp_valid` is 1. `rsp_hit` is 1 exactly when a valid way of the addressed set holds the request tag. On a hit, `rsp_way` gives that way, numbered 0, 1 or 2.
- R3: After reset every way of every set is invalid. The use order of every set is way 2 most recent, way 1, and way 0 least recent.
- R4: On a miss in a set that still has an invalid way, the lowest-numbered invalid way receives the tag. `rsp_way` names that way and `rsp_evict` is 0.
- R5: On a miss in a set whose three ways are all valid, the least recently used way receives the tag. `rsp_way` names that way and `rsp_evict` is 1.
- R6: A hit and a fill both make the accessed way the most recent, and the other two ways keep their relative order. A hit does not change any tag.
- R7: A request reads and changes only the set selected by its index. The other sets keep their tags, valid bits and use order.
- R8: A request accepted in the cycle right after another one sees every change made by the earlier request, including a request to the same set.
- R9: In a cycle where `req_valid` is 0, no state changes. In the cycle after it, `rsp_valid`, `rsp_hit` and `rsp_evict` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with the clock |
| req_valid | input | 1 | Request strobe, one lookup per cycle |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | The tag was found in the set |
| rsp_way | output | 2 | Way that hit or that received the new tag |
| rsp_evict | output | 1 | A valid line was replaced by the fill |

## Verification
The bench goes after the replacement order first. With reset order and fills in ascending way number, a design that starts from the wrong end, or that keeps only the last victim, sends the fourth and later tags of a set to the wrong way. After hits are placed between fills, a design that moves a hit way to the front but scrambles the other two picks a victim that is still in use. Consecutive requests to one set catch a design whose update lands a cycle late, because the second request then misses on a tag that was just installed. Changes to the offset bits and to neighbouring set indices catch a field split that is off by one bit. An unrelated set that later still hits shows that the update stayed in its own set.

// File: rtl/lru3_pkg.sv
package lru3_pkg;

  localparam int NWAYS = 3;

  typedef logic [1:0] way_t;
  typedef logic [2:0] ord_t;

  // use order of one set, most recent first
  typedef struct packed {
    way_t mru;
    way_t mid;
    way_t lru;
  } perm_t;

  localparam ord_t ORD_RESET = 3'd0;

  function automatic perm_t ord_decode(input ord_t code);
    perm_t p;
    case (code)
      3'd1:    p = '{mru: 2'd1, mid: 2'd2, lru: 2'd0};
      3'd2:    p = '{mru: 2'd2, mid: 2'd0, lru: 2'd1};
      3'd3:    p = '{mru: 2'd0, mid: 2'd2, lru: 2'd1};
      3'd4:    p = '{mru: 2'd1, mid: 2'd0, lru: 2'd2};
      3'd5:    p = '{mru: 2'd0, mid: 2'd1, lru: 2'd2};
      default: p = '{mru: 2'd2, mid: 2'd1, lru: 2'd0};
    endcase
    return p;
  endfunction

  function automatic ord_t ord_encode(input perm_t p);
    ord_t code;
    case ({p.mru, p.lru})
      4'b10_00: code = 3'd0;
      4'b01_00: code = 3'd1;
      4'b10_01: code = 3'd2;
      4'b00_01: code = 3'd3;
      4'b01_10: code = 3'd4;
      4'b00_10: code = 3'd5;
      default:  code = ORD_RESET;
    endcase
    return code;
  endfunction

  function automatic perm_t ord_touch(input perm_t p, input way_t w);
    perm_t q;
    if (w == p.mru)      q = p;
    else if (w == p.mid) q = '{mru: w, mid: p.mru, lru: p.lru};
    else                 q = '{mru: w, mid: p.mru, lru: p.mid};
    return q;
  endfunction

endpackage

// File: rtl/lru3_rst_sync.sv
module lru3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lru3_tag_store.sv
module lru3_tag_store
  import lru3_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        srst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [NWAYS-1:0]            rd_vld,
  output logic [NWAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  way_t                        wr_way,
  input  logic [TAG_W-1:0]            wr_tag
);

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic             vld_mem [SETS];
    logic             way_wr;

    assign way_wr    = wr_en && (wr_way == way_t'(g));
    assign rd_tag[g] = tag_mem[rd_idx];
    assign rd_vld[g] = vld_mem[rd_idx];

    always_ff @(posedge clk) begin
      if (way_wr) tag_mem[wr_idx] <= wr_tag;
    end

    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) begin
        for (int s = 0; s < SETS; s++) vld_mem[s] <= 1'b0;
      end else if (way_wr) begin
        vld_mem[wr_idx] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lru3_order_store.sv
module lru3_order_store
  import lru3_pkg::*;
#(
  parameter int SETS = 256,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ord_t             rd_code,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ord_t             wr_code
);

  ord_t ord_mem [SETS];

  assign rd_code = ord_mem[rd_idx];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int s = 0; s < SETS; s++) ord_mem[s] <= ORD_RESET;
    end else if (wr_en) begin
      ord_mem[wr_idx] <= wr_code;
    end
  end

  AST_ORDER_CODE_LEGAL: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en |-> (wr_code < 3'd6)); // R3

endmodule

// File: rtl/lru3_way_select.sv
module lru3_way_select
  import lru3_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic [NWAYS-1:0]            way_vld,
  input  logic [NWAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]            req_tag,
  input  ord_t                        ord_code,
  output logic [NWAYS-1:0]            match,
  output logic                        hit,
  output way_t                        acc_way,
  output logic                        evicts,
  output ord_t                        ord_next
);

  for (genvar g = 0; g < NWAYS; g++) begin : g_cmp
    assign match[g] = way_vld[g] && (way_tag[g] == req_tag);
  end

  perm_t cur_order;
  way_t  hit_way;
  way_t  free_way;
  logic  set_full;

  always_comb begin
    cur_order = ord_decode(ord_code);
    hit       = |match;
    set_full  = &way_vld;
    hit_way   = '0;
    free_way  = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (match[i])    hit_way  = way_t'(i);
      if (!way_vld[i]) free_way = way_t'(i);
    end
    if (hit)           acc_way = hit_way;
    else if (set_full) acc_way = cur_order.lru;
    else               acc_way = free_way;
    evicts   = !hit && set_full;
    ord_next = ord_encode(ord_touch(cur_order, acc_way));
  end

endmodule

// File: rtl/lru3_tag_unit.sv
module lru3_tag_unit
  import lru3_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [1:0]        rsp_way,
  output logic              rsp_evict
);

  localparam int OFFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;

  logic                        srst_n;
  logic [IDX_W-1:0]            req_idx;
  logic [TAG_W-1:0]            req_tag;
  logic [NWAYS-1:0]            rd_vld;
  logic [NWAYS-1:0][TAG_W-1:0] rd_tag;
  ord_t                        rd_code;
  logic [NWAYS-1:0]            match;
  logic                        hit_c;
  way_t                        acc_way;
  logic                        evict_c;
  ord_t                        ord_next;
  logic                        tag_wr;

  logic             rsp_valid_d, rsp_hit_d, rsp_evict_d;
  way_t             rsp_way_d;
  logic [IDX_W-1:0] rsp_idx_q;

  assign req_idx = req_addr[OFFS_W +: IDX_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign tag_wr  = req_valid && !hit_c;

  lru3_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  lru3_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .srst_n (srst_n),
    .rd_idx (req_idx),
    .rd_vld (rd_vld),
    .rd_tag (rd_tag),
    .wr_en  (tag_wr),
    .wr_idx (req_idx),
    .wr_way (acc_way),
    .wr_tag (req_tag)
  );

  lru3_order_store #(.SETS(SETS)) u_order (
    .clk     (clk),
    .srst_n  (srst_n),
    .rd_idx  (req_idx),
    .rd_code (rd_code),
    .wr_en   (req_valid),
    .wr_idx  (req_idx),
    .wr_code (ord_next)
  );

  lru3_way_select #(.TAG_W(TAG_W)) u_sel (
    .way_vld  (rd_vld),
    .way_tag  (rd_tag),
    .req_tag  (req_tag),
    .ord_code (rd_code),
    .match    (match),
    .hit      (hit_c),
    .acc_way  (acc_way),
    .evicts   (evict_c),
    .ord_next (ord_next)
  );

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && hit_c;
    rsp_evict_d = req_valid && evict_c;
    rsp_way_d   = req_valid ? acc_way : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_way   <= '0;
      rsp_idx_q <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_evict <= rsp_evict_d;
      rsp_way   <= rsp_way_d;
      if (req_valid) rsp_idx_q <= req_idx;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid |-> $onehot0(match)); // R2

  AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_valid |-> (rsp_way != 2'd3)); // R2

  AST_FREE_NO_EVICT: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && !hit_c && !(&rd_vld)) |=> !rsp_evict); // R4

  AST_EVICT_NOT_HIT: assert property (@(posedge clk) disable iff (!srst_n)
    rsp_evict |-> !rsp_hit); // R5

  AST_RSP_WAY_MRU: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && req_idx == rsp_idx_q) |-> (ord_decode(rd_code).mru == rsp_way)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_evict)); // R9

endmodule

// File: tb/sim_lru3_tag_unit.sv
`timescale 1ns/1ps
module sim_lru3_tag_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [1:0]  rsp_way;
  logic        rsp_evict;

  int n_run;
  int n_fail;
  bit finished;

  bit         mv [256][3];
  logic [19:0] mt [256][3];
  int         mo [256][3]; // mo[s][0] most recent

  lru3_tag_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .rsp_evict (rsp_evict)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 256; s++) begin
      for (int w = 0; w < 3; w++) begin
        mv[s][w] = 1'b0;
        mt[s][w] = '0;
      end
      mo[s][0] = 2; mo[s][1] = 1; mo[s][2] = 0;
    end
  endtask

  task automatic access(input int set, input logic [19:0] tag, input logic [3:0] off,
                        input string req);
    int eh, ew, ee, k;
    int nlist [3];
    eh = 0; ew = -1; ee = 0;
    for (int w = 0; w < 3; w++)
      if (mv[set][w] && mt[set][w] == tag) begin eh = 1; ew = w; end
    if (eh == 0) begin
      for (int w = 2; w >= 0; w--) if (!mv[set][w]) ew = w;
      if (ew < 0) begin ew = mo[set][2]; ee = 1; end
      mv[set][ew] = 1'b1;
      mt[set][ew] = tag;
    end
    nlist[0] = ew; k = 1;
    for (int i = 0; i < 3; i++)
      if (mo[set][i] != ew) begin nlist[k] = mo[set][i]; k++; end
    for (int i = 0; i < 3; i++) mo[set][i] = nlist[i];

    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {tag, set[7:0], off};
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_hit",   int'(rsp_hit),   eh);
    chk(req, "rsp_way",   int'(rsp_way),   ew);
    chk(req, "rsp_evict", int'(rsp_evict), ee);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = 32'hFFFF_FFF0;
      @(posedge clk);
      #1;
      chk(req, "idle rsp_valid", int'(rsp_valid), 0);
      chk(req, "idle rsp_hit",   int'(rsp_hit),   0);
      chk(req, "idle rsp_evict", int'(rsp_evict), 0);
    end
  endtask

  // R3: reset state and first fills
  task automatic t_reset();
    chk("R3", "reset rsp_valid", int'(rsp_valid), 0);
    chk("R3", "reset rsp_hit",   int'(rsp_hit),   0);
    access(5, 20'h11111, 4'h0, "R3");
  endtask

  // R4: free ways fill in ascending order without eviction
  task automatic t_fill_free();
    access(5, 20'h22222, 4'h3, "R4");
    access(5, 20'h33333, 4'h7, "R4");
    access(5, 20'h44444, 4'h1, "R5");
  endtask

  // R5 R6: hit between fills steers the victim
  task automatic t_sequence();
    access(9, 20'h00010, 4'h0, "R4");
    access(9, 20'h8A02F, 4'h0, "R4");
    access(9, 20'h00010, 4'h0, "R6");
    access(9, 20'hF1EEE, 4'h0, "R4");
    access(9, 20'h5A5A5, 4'h0, "R5");
    access(9, 20'h00010, 4'h0, "R6");
    access(9, 20'h8A02F, 4'h0, "R5");
  endtask

  // R1: offset bits ignored, neighbouring index misses
  task automatic t_fields();
    access(40, 20'hABCDE, 4'h0, "R1");
    access(40, 20'hABCDE, 4'hF, "R1");
    access(41, 20'hABCDE, 4'h8, "R1");
    access(40, 20'hABCDF, 4'h8, "R1");
  endtask

  // R7: work in one set leaves others alone
  task automatic t_sets();
    for (int i = 0; i < 6; i++) access(200, 20'h70000 + 20'(i), 4'h2, "R7");
    access(40, 20'hABCDE, 4'h4, "R7");
    access(41, 20'hABCDE, 4'h4, "R7");
  endtask

  // R8: back-to-back to same set
  task automatic t_b2b();
    access(77, 20'h0BEEF, 4'h0, "R8");
    access(77, 20'h0BEEF, 4'h9, "R8");
    access(77, 20'h0CAFE, 4'h0, "R8");
    access(77, 20'h0CAFE, 4'h0, "R8");
  endtask

  // R9: idle cycles change nothing
  task automatic t_idle();
    idle(3, "R9");
    access(77, 20'h0BEEF, 4'h0, "R9");
    access(9, 20'h8A02F, 4'h0, "R9");
  endtask

  // R2 R5 R6: pseudo-random mix over a few sets and tags
  task automatic t_mix();
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(120 + int'(lf[1:0]), 20'h3C000 + 20'(lf[6:4] % 3'd5), lf[11:8], "R2");
    end
  endtask

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    model_reset();
    #55 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_fill_free();
    t_sequence();
    t_fields();
    t_sets();
    t_b2b();
    t_idle();
    t_mix();
    idle(1, "R9");
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule